// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execute unit of a processor datapath. It takes two operands of a configurable width (32 bits by default), already chosen between a register value and an immediate. It applies one of eight operations: add, subtract, and six bitwise functions. Three of the bitwise functions invert operand b or the output. The result leaves the block combinationally in the same cycle as the inputs.

Every operation can also update a four-bit condition register holding negative, zero, overflow and carry. The register loads on the rising clock edge only when the set-flags input is high. In all other cycles it keeps its value, so a branch unit further down the pipeline can test the flags of an earlier operation.

Subtraction is performed as a plus the two's complement of b. Its carry flag is the inverse of the adder's carry out, so after a subtract the flag reads as a borrow: it is set exactly when a is unsigned-less-than b.

Top module: `cc_alu`

## Requirements
- R1: Opcode 0 gives result = a + b and opcode 1 gives result = a - b, both modulo 2^WIDTH.
- R2: Opcodes 2 to 7 give a & b, a & ~b, a | b, a | ~b, a ^ b and ~(a ^ b), in that order.
- R3: When flags load, the zero flag (flags bit 2) is 1 exactly when every result bit is 0.
- R4: When flags load, the negative flag (flags bit 3) equals the result's most significant bit.
- R5: When an add loads flags, carry (bit 0) is the carry out of the top bit. Overflow (bit 1) is set when both operands share a sign and the result's sign differs from it.
- R6: When a subtract loads flags, carry (bit 0) is set when the adder produces no carry out, which means a < b unsigned. Overflow (bit 1) is set when the result's sign equals b's sign and a's sign differs from b's.
- R7: When a bitwise operation loads flags, overflow and carry are both cleared.
- R8: The flag register resets to 0000. It changes only on a clock edge where set_flags is 1, and otherwise holds its value.
- R9: The result depends only on a, b and opcode in the same cycle, whatever the state of set_flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| op_a | input | WIDTH | First operand (minuend on subtract) |
| op_b | input | WIDTH | Second operand, register or immediate (subtrahend) |
| opcode | input | 3 | Operation select, encoding as in R1 and R2 |
| set_flags | input | 1 | Load the flag register at the next edge |
| result | output | WIDTH | Combinational result |
| flags | output | 4 | Registered flags {N, Z, V, C}, bits 3 to 0 |

## Verification
The bench targets the operand pairs at the edges of the number ranges. An unsigned add that wraps to zero must raise zero and carry together. Adding to the most positive value must flip the sign and set overflow. Subtracting from the most negative value must set overflow but not carry, and a smaller minus a larger unsigned value must set carry as a borrow. A design that passed the raw adder carry through on subtraction would show the carry flag inverted on every subtract. A design that kept overflow or carry on the bitwise operations would leave stale bits set after an arithmetic overflow. A design that loaded flags without checking the enable would overwrite the held flags during cycles whose enable is low.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_ANDN = 3'd3,
    OP_OR   = 3'd4,
    OP_ORN  = 3'd5,
    OP_XOR  = 3'd6,
    OP_XNOR = 3'd7
  } alu_op_e;

  localparam int FLAG_W = 4;
  localparam int FLG_N  = 3;
  localparam int FLG_Z  = 2;
  localparam int FLG_V  = 1;
  localparam int FLG_C  = 0;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } cc_flags_t;

endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             adder_cout,
  output logic             carry_flag,
  output logic             ovf_flag
);
  localparam int MSB = WIDTH - 1;

  // Full-width adder with carry in; subtraction feeds ~b and carry in of 1.
  function automatic logic [WIDTH:0] add_with_cin(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             cin
  );
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  // Signed overflow: add when operand signs agree and sum sign differs;
  // subtract when result sign matches b and a's sign differs from b.
  function automatic logic signed_ovf(
    input logic sa,
    input logic sb,
    input logic sr,
    input logic sub
  );
    if (sub) return (sr == sb) && (sa != sb);
    return (sa == sb) && (sr != sa);
  endfunction

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff      = do_sub ? ~b : b;
    wide       = add_with_cin(a, b_eff, do_sub);
    sum        = wide[WIDTH-1:0];
    adder_cout = wide[WIDTH];
    carry_flag = do_sub ? ~adder_cout : adder_cout;
    ovf_flag   = signed_ovf(a[MSB], b[MSB], sum[MSB], do_sub);
  end

endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       sel,
  output logic [WIDTH-1:0] res
);
  import cc_alu_pkg::*;

  // Base function picked by sel[2:1]; sel[0] inverts b (and/or) or the output (xor).
  function automatic logic [WIDTH-1:0] eval_bitwise(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic [2:0]       s
  );
    logic [WIDTH-1:0] y_eff;
    y_eff = s[0] ? ~y : y;
    case (s[2:1])
      2'b01:   return x & y_eff;
      2'b10:   return x | y_eff;
      2'b11:   return x ^ y_eff;
      default: return '0;
    endcase
  endfunction

  assign res = eval_bitwise(a, b, sel);

endmodule

// File: rtl/cc_alu_flagreg.sv
module cc_alu_flagreg (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  cc_alu_pkg::cc_flags_t d,
  output cc_alu_pkg::cc_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       opcode,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags
);
  import cc_alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  // Named internal events, visible to the bound checker.
  logic             is_sub;
  logic             is_logic;
  logic [WIDTH-1:0] arith_sum;
  logic [WIDTH-1:0] logic_res;
  logic             arith_cout;
  logic             arith_carry;
  logic             arith_ovf;
  cc_flags_t        next_flags;
  cc_flags_t        flag_q;

  assign is_sub   = (alu_op_e'(opcode) == OP_SUB);
  assign is_logic = |opcode[2:1];

  cc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a          (op_a),
    .b          (op_b),
    .do_sub     (is_sub),
    .sum        (arith_sum),
    .adder_cout (arith_cout),
    .carry_flag (arith_carry),
    .ovf_flag   (arith_ovf)
  );

  cc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .sel (opcode),
    .res (logic_res)
  );

  assign result = is_logic ? logic_res : arith_sum;

  always_comb begin
    next_flags.neg   = result[MSB];
    next_flags.zero  = ~|result;
    next_flags.ovf   = is_logic ? 1'b0 : arith_ovf;
    next_flags.carry = is_logic ? 1'b0 : arith_carry;
  end

  cc_alu_flagreg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (set_flags),
    .d     (next_flags),
    .q     (flag_q)
  );

  assign flags = flag_q;

endmodule

// File: rtl/cc_alu_checker.sv
module cc_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       opcode,
  input logic             set_flags,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flags,
  input logic             is_sub,
  input logic             is_logic,
  input logic             arith_cout
);
  logic [WIDTH:0] plain_sum;
  assign plain_sum = {1'b0, op_a} + {1'b0, op_b};

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(flags));

  assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flags[2] == ($past(result) == '0));

  assert_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flags[3] == $past(result[WIDTH-1]));

  assert_logic_vc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && is_logic) |=> flags[1:0] == 2'b00);

  assert_add_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && opcode == 3'd0) |=> flags[0] == $past(plain_sum[WIDTH]));

  assert_sub_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && opcode == 3'd1) |=> flags[0] == $past(op_a < op_b));

  assert_sub_cout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_sub |-> arith_cout == (op_a >= op_b));

  assert_sub_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 3'd1) |-> result == op_a - op_b);

endmodule

bind cc_alu cc_alu_checker #(.WIDTH(WIDTH)) u_cc_alu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_a       (op_a),
  .op_b       (op_b),
  .opcode     (opcode),
  .set_flags  (set_flags),
  .result     (result),
  .flags      (flags),
  .is_sub     (is_sub),
  .is_logic   (is_logic),
  .arith_cout (arith_cout)
);

// File: tb/test_cc_alu.sv
module test_cc_alu;
  localparam int W = 32;
  localparam logic [W-1:0] MAXP = 32'h7FFF_FFFF;
  localparam logic [W-1:0] MINN = 32'h8000_0000;
  localparam logic [W-1:0] ONES = 32'hFFFF_FFFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [2:0]   opcode = 3'd0;
  logic         set_flags = 1'b0;
  logic [W-1:0] result;
  logic [3:0]   flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] q_res[$];
  logic [3:0]   q_flg[$];
  string        q_tag[$];
  logic [3:0]   model_flags = 4'b0000;

  always #10 clk = ~clk;

  cc_alu #(.WIDTH(W)) i_cc_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .set_flags(set_flags), .result(result), .flags(flags)
  );

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model built from signed/unsigned integer arithmetic.
  task automatic drive(input string tag, input logic [2:0] op,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sf);
    longint ua, ub, sa, sb, wide;
    logic [W-1:0] r;
    logic v, c;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; set_flags = sf;
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    sa = longint'(signed'(a)); sb = longint'(signed'(b));
    v = 1'b0; c = 1'b0;
    case (op)
      3'd0: begin r = a + b; c = (ua + ub) > longint'({32'd0, ONES});
              wide = sa + sb; v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      3'd1: begin r = a - b; c = ua < ub;
              wide = sa - sb; v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      3'd2: r = a & b;
      3'd3: r = a & ~b;
      3'd4: r = a | b;
      3'd5: r = a | ~b;
      3'd6: r = a ^ b;
      default: r = ~(a ^ b);
    endcase
    if (sf) model_flags = {r[W-1], (r == '0), v, c};
    q_res.push_back(r);
    q_flg.push_back(model_flags);
    q_tag.push_back(tag);
  endtask

  // Monitor: result compared before the edge, flags after it.
  initial begin
    forever begin
      @(posedge clk);
      if (q_res.size() != 0) begin
        logic [W-1:0] er;
        logic [3:0] ef;
        string t;
        er = q_res.pop_front();
        ef = q_flg.pop_front();
        t  = q_tag.pop_front();
        check(t, "result", result, er);
        @(negedge clk);
        check(t, "flags", {28'd0, flags}, {28'd0, ef});
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R8", "reset flags", {28'd0, flags}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    drive("R1", 3'd0, 32'd5, 32'd7, 1'b1);
    drive("R5", 3'd0, ONES, 32'd1, 1'b1);
    drive("R5", 3'd0, MAXP, 32'd1, 1'b1);
    drive("R5", 3'd0, MINN, MINN, 1'b1);
    drive("R6", 3'd1, 32'd12, 32'd9, 1'b1);
    drive("R6", 3'd1, 32'd9, 32'd12, 1'b1);
    drive("R6", 3'd1, MINN, 32'd2, 1'b1);
    drive("R3", 3'd1, 32'd5, 32'd5, 1'b1);
    drive("R6", 3'd1, MAXP, ONES, 1'b1);
    drive("R5", 3'd0, MINN, MINN, 1'b1);
    drive("R7", 3'd7, 32'h0F0F_00FF, 32'h0F0F_0F0F, 1'b1);
    drive("R2", 3'd2, 32'hF0F0_1234, 32'h0F0F_4321, 1'b1);
    drive("R2", 3'd3, 32'hFFFF_0000, 32'h00FF_00FF, 1'b1);
    drive("R4", 3'd4, 32'h8000_0001, 32'h0000_0010, 1'b1);
    drive("R2", 3'd5, 32'h0000_0000, ONES, 1'b1);
    drive("R2", 3'd6, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b1);
    drive("R5", 3'd0, MAXP, MAXP, 1'b1);
    drive("R8", 3'd1, 32'd0, 32'd0, 1'b0);
    drive("R9", 3'd0, ONES, ONES, 1'b0);
    drive("R8", 3'd6, MINN, 32'd0, 1'b0);
    drive("R2", 3'd5, 32'h1234_5678, 32'hFFFF_0000, 1'b1);
    drive("R1", 3'd0, 32'hDEAD_BEEF, 32'h1111_1111, 1'b1);
    drive("R9", 3'd4, 32'h0, 32'h0, 1'b0);
    @(negedge clk);
    set_flags = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule